// File: doc/BRIEF.md
# Dataflow node schedule controller

This block sequences a five-stage processing chain (A, B, C, D, E) from a central point. A new 8-bit sample arrives with each rising edge of a slow sample clock. That edge is carried into the fast circuit-clock domain and launches one pass through the chain. The controller sends each node a single-cycle start strobe together with its operand on a shared 8-bit operand bus. It picks up each node's result at the moment that node is known to be finished, and hands the result to the next node one cycle later.

Node A is combinational, so its result is taken in the same cycle it is loaded. Nodes B, C and E have fixed latencies of 7, 8 and 9 circuit cycles, which a single shared timer measures. Node D takes a data-dependent 3 to 8 cycles and reports completion with a done pulse. When E finishes, the final value is registered and flagged with a one-cycle valid pulse. A sample edge that arrives while a pass is in flight is dropped and reported.

Top module: `node_sched_ctrl`

## Requirements
- R1: While rst_ni is low, every strobe, res_valid_o and overrun_o is low, and any pass in progress is abandoned without producing a result.
- R2: Each rising edge of smp_clk_i that reaches an idle controller starts exactly one pass. a_ld_o pulses for one cycle, and node_din_o carries the value that sample_i held at that edge.
- R3: Node A is treated as combinational. b_start_o pulses in the cycle right after a_ld_o, and node_din_o then carries the value a_res_i had during the a_ld_o cycle.
- R4: c_start_o pulses exactly 8 cycles after b_start_o, so b_res_i is taken 7 cycles after B's start. node_din_o then carries that value.
- R5: d_start_o pulses exactly 9 cycles after c_start_o, so c_res_i is taken 8 cycles after C's start.
- R6: e_start_o pulses in the cycle after the first cycle in which d_done_i is high following d_start_o, for any D latency from 3 to 8. node_din_o then carries d_res_i from the done cycle.
- R7: res_valid_o pulses for one cycle exactly 10 cycles after e_start_o. res_o then holds the value of e_res_i taken 9 cycles after e_start_o, and the controller is idle again.
- R8: A sample edge that arrives while a pass is in progress starts nothing. overrun_o pulses for one cycle, and the pass in flight completes with its own result.
- R9: All strobes are single-cycle pulses, and at most one of a_ld_o, b_start_o, c_start_o, d_start_o and e_start_o is high in any cycle.
- R10: res_o equals the composition E(D(C(B(A(sample))))) of the node results along the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast circuit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_clk_i | input | 1 | Slow sample clock; each rising edge offers a sample |
| sample_i | input | 8 | Input sample, stable around the sample-clock rising edge |
| node_din_o | output | 8 | Shared operand bus, latched by the node being started |
| a_ld_o | output | 1 | Load strobe for combinational node A |
| a_res_i | input | 8 | Node A result |
| b_start_o | output | 1 | Start strobe for node B |
| b_res_i | input | 8 | Node B result |
| c_start_o | output | 1 | Start strobe for node C |
| c_res_i | input | 8 | Node C result |
| d_start_o | output | 1 | Start strobe for node D |
| d_done_i | input | 1 | Node D completion pulse |
| d_res_i | input | 8 | Node D result |
| e_start_o | output | 1 | Start strobe for node E |
| e_res_i | input | 8 | Node E result |
| res_o | output | 8 | Final chain result |
| res_valid_o | output | 1 | One-cycle pulse marking res_o as new |
| overrun_o | output | 1 | One-cycle pulse when a sample edge is dropped |

## Verification
In the bench, each node stub presents its correct result only in the exact cycle its latency expires and a corrupted value in every other cycle. A controller that samples a fixed-latency node one cycle early or late therefore delivers a wrong final value, and the measured gap between start strobes is also off by one. Node D is driven at both latency extremes, 3 and 8, as well as in between, to catch a controller that counts a fixed delay instead of following the done pulse. A second sample edge is injected mid-pass to expose a controller that restarts, corrupts the current pass or emits a second result. A reset is also applied mid-pass to catch a controller that leaks a stale valid pulse afterwards.

// File: rtl/node_sched_pkg.sv
package node_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_A    = 3'd1,
    ST_B    = 3'd2,
    ST_C    = 3'd3,
    ST_D    = 3'd4,
    ST_E    = 3'd5
  } sched_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ns_tick_sync.sv
module ns_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic tick_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ns_lat_timer.sv
module ns_lat_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // cycle of the start strobe counts as 0; expiry when count reaches limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= CNT_W'(1);
    else if (en_i && !expire_o)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire_o = en_i & ~start_i & (cnt_q == limit_i);

endmodule

// File: rtl/node_sched_ctrl.sv
module node_sched_ctrl
  import node_sched_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LAT_B       = 7,
  parameter int LAT_C       = 8,
  parameter int LAT_E       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_clk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] node_din_o,
  output logic              a_ld_o,
  input  logic [DATA_W-1:0] a_res_i,
  output logic              b_start_o,
  input  logic [DATA_W-1:0] b_res_i,
  output logic              c_start_o,
  input  logic [DATA_W-1:0] c_res_i,
  output logic              d_start_o,
  input  logic              d_done_i,
  input  logic [DATA_W-1:0] d_res_i,
  output logic              e_start_o,
  input  logic [DATA_W-1:0] e_res_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic              overrun_o
);

  localparam int LAT_MAX = max3(LAT_B, LAT_C, LAT_E);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  sched_st_e         st_q;
  logic [DATA_W-1:0] din_q, res_q;
  logic              a_ld_q, b_st_q, c_st_q, d_st_q, e_st_q;
  logic              vld_q, ovr_q;
  logic              tick;
  logic              tmr_start, tmr_en, tmr_exp;
  logic [CNT_W-1:0]  tmr_limit;

  ns_tick_sync #(
    .STAGES (SYNC_STAGES)
  ) u_tick_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (smp_clk_i),
    .tick_o  (tick)
  );

  // one timer shared by the three fixed-latency nodes
  assign tmr_start = b_st_q | c_st_q | e_st_q;
  assign tmr_en    = (st_q == ST_B) | (st_q == ST_C) | (st_q == ST_E);

  always_comb begin
    unique case (st_q)
      ST_B:    tmr_limit = CNT_W'(LAT_B);
      ST_C:    tmr_limit = CNT_W'(LAT_C);
      default: tmr_limit = CNT_W'(LAT_E);
    endcase
  end

  ns_lat_timer #(
    .CNT_W (CNT_W)
  ) u_lat_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .en_i     (tmr_en),
    .limit_i  (tmr_limit),
    .expire_o (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      din_q  <= '0;
      res_q  <= '0;
      a_ld_q <= 1'b0;
      b_st_q <= 1'b0;
      c_st_q <= 1'b0;
      d_st_q <= 1'b0;
      e_st_q <= 1'b0;
      vld_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      a_ld_q <= 1'b0;
      b_st_q <= 1'b0;
      c_st_q <= 1'b0;
      d_st_q <= 1'b0;
      e_st_q <= 1'b0;
      vld_q  <= 1'b0;
      ovr_q  <= tick & (st_q != ST_IDLE);
      unique case (st_q)
        ST_IDLE: if (tick) begin
          din_q  <= sample_i;
          a_ld_q <= 1'b1;
          st_q   <= ST_A;
        end
        ST_A: begin
          din_q  <= a_res_i;
          b_st_q <= 1'b1;
          st_q   <= ST_B;
        end
        ST_B: if (tmr_exp) begin
          din_q  <= b_res_i;
          c_st_q <= 1'b1;
          st_q   <= ST_C;
        end
        ST_C: if (tmr_exp) begin
          din_q  <= c_res_i;
          d_st_q <= 1'b1;
          st_q   <= ST_D;
        end
        ST_D: if (d_done_i && !d_st_q) begin
          din_q  <= d_res_i;
          e_st_q <= 1'b1;
          st_q   <= ST_E;
        end
        ST_E: if (tmr_exp) begin
          res_q <= e_res_i;
          vld_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign node_din_o  = din_q;
  assign a_ld_o      = a_ld_q;
  assign b_start_o   = b_st_q;
  assign c_start_o   = c_st_q;
  assign d_start_o   = d_st_q;
  assign e_start_o   = e_st_q;
  assign res_o       = res_q;
  assign res_valid_o = vld_q;
  assign overrun_o   = ovr_q;

endmodule

// File: rtl/node_sched_chk.sv
module node_sched_chk #(
  parameter int LAT_B = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic a_ld_o,
  input logic b_start_o,
  input logic c_start_o,
  input logic d_start_o,
  input logic d_done_i,
  input logic e_start_o,
  input logic res_valid_o,
  input logic overrun_o
);

  logic       in_d_q;
  logic [5:0] since_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_d_q    <= 1'b0;
      since_b_q <= '0;
    end else begin
      if (d_start_o)     in_d_q <= 1'b1;
      else if (d_done_i) in_d_q <= 1'b0;
      if (b_start_o)                                 since_b_q <= 6'd1;
      else if (since_b_q != 0 && since_b_q != 6'h3f) since_b_q <= since_b_q + 6'd1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_ld_o, b_start_o, c_start_o, d_start_o, e_start_o})); // R9
  AST_B_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_start_o |=> !b_start_o); // R9
  AST_E_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_start_o |=> !e_start_o); // R9
  AST_A_THEN_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_ld_o |=> b_start_o); // R3
  AST_B_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_start_o |-> (since_b_q == 6'(LAT_B + 1))); // R4
  AST_D_DONE_TO_E: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_d_q && d_done_i) |=> e_start_o); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R7
  AST_OVR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o); // R8

endmodule

bind node_sched_ctrl node_sched_chk #(
  .LAT_B (LAT_B)
) u_node_sched_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_ld_o      (a_ld_o),
  .b_start_o   (b_start_o),
  .c_start_o   (c_start_o),
  .d_start_o   (d_start_o),
  .d_done_i    (d_done_i),
  .e_start_o   (e_start_o),
  .res_valid_o (res_valid_o),
  .overrun_o   (overrun_o)
);

// File: tb/tb_node_sched_ctrl.sv
module tb_node_sched_ctrl;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_clk = 1'b0;
  logic [7:0] sample = 8'h00;
  logic [7:0] node_din, a_res, b_res, c_res, d_res, e_res, res;
  logic       a_ld, b_start, c_start, d_start, d_done, e_start, res_valid, overrun;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, vld_cnt = 0, ovr_cnt = 0;
  int a_t, b_t, c_t, d_t, e_t, d_lat_run;
  int d_lat_cfg = 3;
  logic [7:0] exp_q[$];
  logic       fin = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] fa(input logic [7:0] x); return x + 8'd1; endfunction
  function automatic logic [7:0] fb(input logic [7:0] x); return x ^ 8'h5A; endfunction
  function automatic logic [7:0] fc(input logic [7:0] x); return x + 8'h11; endfunction
  function automatic logic [7:0] fd(input logic [7:0] x); return {x[6:0], x[7]}; endfunction
  function automatic logic [7:0] fe(input logic [7:0] x); return x - 8'h03; endfunction

  node_sched_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_clk_i(smp_clk), .sample_i(sample),
    .node_din_o(node_din), .a_ld_o(a_ld), .a_res_i(a_res),
    .b_start_o(b_start), .b_res_i(b_res), .c_start_o(c_start), .c_res_i(c_res),
    .d_start_o(d_start), .d_done_i(d_done), .d_res_i(d_res),
    .e_start_o(e_start), .e_res_i(e_res),
    .res_o(res), .res_valid_o(res_valid), .overrun_o(overrun)
  );

  // node stubs: correct result only in the expiry cycle
  logic [7:0] bx, cx, dx, ex;
  logic [3:0] b_age, c_age, d_age, e_age, d_lim;

  assign a_res  = fa(node_din);
  assign b_res  = (b_age == 4'd7) ? fb(bx) : ~fb(bx);
  assign c_res  = (c_age == 4'd8) ? fc(cx) : ~fc(cx);
  assign d_done = (d_age != 0) && (d_age == d_lim);
  assign d_res  = d_done ? fd(dx) : ~fd(dx);
  assign e_res  = (e_age == 4'd9) ? fe(ex) : ~fe(ex);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      b_age <= 0; c_age <= 0; d_age <= 0; e_age <= 0; d_lim <= 0;
      bx <= 0; cx <= 0; dx <= 0; ex <= 0;
    end else begin
      if (b_start) begin bx <= node_din; b_age <= 1; end
      else if (b_age != 0 && b_age != 4'hf) b_age <= b_age + 1;
      if (c_start) begin cx <= node_din; c_age <= 1; end
      else if (c_age != 0 && c_age != 4'hf) c_age <= c_age + 1;
      if (d_start) begin dx <= node_din; d_age <= 1; d_lim <= 4'(d_lat_cfg); end
      else if (d_done) d_age <= 0;
      else if (d_age != 0) d_age <= d_age + 1;
      if (e_start) begin ex <= node_din; e_age <= 1; end
      else if (e_age != 0 && e_age != 4'hf) e_age <= e_age + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (a_ld || b_start || c_start || d_start || e_start)
        check($countones({a_ld, b_start, c_start, d_start, e_start}) == 1, "R9",
              $countones({a_ld, b_start, c_start, d_start, e_start}), 1);
      if (a_ld) begin
        a_t = cyc;
        check(exp_q.size() > 0 && node_din == exp_q[0], "R2", node_din,
              exp_q.size() > 0 ? exp_q[0] : 0);
      end
      if (b_start) begin
        check(cyc - a_t == 1, "R3 timing", cyc - a_t, 1);
        check(node_din == fa(exp_q[0]), "R3 data", node_din, fa(exp_q[0]));
        b_t = cyc;
      end
      if (c_start) begin
        check(cyc - b_t == 8, "R4 timing", cyc - b_t, 8);
        check(node_din == fb(fa(exp_q[0])), "R4 data", node_din, fb(fa(exp_q[0])));
        c_t = cyc;
      end
      if (d_start) begin
        check(cyc - c_t == 9, "R5", cyc - c_t, 9);
        d_t = cyc; d_lat_run = d_lat_cfg;
      end
      if (e_start) begin
        check(cyc - d_t == d_lat_run + 1, "R6", cyc - d_t, d_lat_run + 1);
        e_t = cyc;
      end
      if (overrun) ovr_cnt++;
      if (res_valid) begin
        vld_cnt++;
        check(cyc - e_t == 10, "R7", cyc - e_t, 10);
        if (exp_q.size() == 0) check(1'b0, "R8 extra result", res, 0);
        else begin
          logic [7:0] x;
          x = exp_q.pop_front();
          check(res == fe(fd(fc(fb(fa(x))))), "R10", res, fe(fd(fc(fb(fa(x))))));
        end
      end
    end
  end

  task automatic edge_smp(input logic [7:0] v);
    @(negedge clk);
    sample = v; smp_clk = 1'b1;
    repeat (4) @(negedge clk);
    smp_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_pass(input logic [7:0] v, input int lat);
    int v0;
    v0 = vld_cnt;
    d_lat_cfg = lat;
    exp_q.push_back(v);
    edge_smp(v);
    for (int i = 0; i < 100 && vld_cnt == v0; i++) @(negedge clk);
    check(vld_cnt == v0 + 1, "R2 pass count", vld_cnt, v0 + 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_quiet(input string req);
    check({a_ld, b_start, c_start, d_start, e_start, res_valid, overrun} == 0, req,
          {a_ld, b_start, c_start, d_start, e_start, res_valid, overrun}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1 reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    run_pass(8'h00, 3);
    run_pass(8'hFF, 8);
    run_pass(8'h5C, 5);
    run_pass(8'h81, 4);
    run_pass(8'h37, 8);
    run_pass(8'hA0, 3);

    // R8: second edge during a pass
    begin
      int v0, o0;
      v0 = vld_cnt; o0 = ovr_cnt;
      d_lat_cfg = 6;
      exp_q.push_back(8'h42);
      edge_smp(8'h42);
      repeat (6) @(negedge clk);
      edge_smp(8'h99);
      for (int i = 0; i < 100 && vld_cnt == v0; i++) @(negedge clk);
      repeat (30) @(negedge clk);
      check(ovr_cnt == o0 + 1, "R8 overrun", ovr_cnt, o0 + 1);
      check(vld_cnt == v0 + 1, "R8 single result", vld_cnt, v0 + 1);
    end

    // R1: reset mid-pass
    begin
      int v0;
      v0 = vld_cnt;
      d_lat_cfg = 5;
      exp_q.push_back(8'h11);
      edge_smp(8'h11);
      repeat (4) @(negedge clk);
      rst_ni = 1'b0;
      repeat (2) @(negedge clk);
      check_quiet("R1 mid-pass reset");
      exp_q.delete();
      rst_ni = 1'b1;
      repeat (60) @(negedge clk);
      check(vld_cnt == v0, "R1 no stale result", vld_cnt, v0);
    end

    run_pass(8'h7E, 7);
    check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule